// File: doc/BRIEF.md
# Compressed Branch Resolver

This unit resolves one compressed branch per cycle. It takes fields that have already been decoded from a 16-bit branch instruction, together with the program counter, the 32-bit condition register, the link register and the count register. From these it decides whether the branch is taken and gives the next fetch address. It also gives the value for the link register when linking is requested, and the decremented count value when the instruction uses the counter. The results are registered, so they appear one clock after the request.

It handles three kinds of branch. The first is the PC-relative branch. The second is the branch to the address held in the link register. The third is the conditional branch with a short immediate offset, which exists only in the wider 16-bit decoding mode. The unit supports two decoding modes. The narrow mode gives a small condition check limited to the first condition field. The wide mode adds extension bits that widen the offset and the reach of the condition-bit index. Offsets count in halfwords, and no form gives an absolute address.

Top module: `cbr_unit`

## Requirements
- R1: `out_valid` rises one cycle after each `in_valid` and is low in a cycle with no request. Synchronous reset clears `out_valid`, `taken`, `lr_we` and `ctr_we`.
- R2: In narrow mode (`wide`=0), `bo[0]`=1 enables a test of condition bit `bi[1:0]`. Condition bit k is `cr[31-k]`. `bo[1]`=1 inverts the tested bit. With `bo[0]`=0 the test passes. `bi[4:2]` is ignored.
- R3: In wide mode, relative and link-register branches test condition bit `bi[4:0]`, which can be any of the 32 bits, under the same enable and invert rules.
- R4: A conditional branch (`kind`=2) is legal only in wide mode. Its test is always enabled whatever `bo[0]` is, `bo[1]` inverts it, and it tests condition bit `bi[2:0]` (bits 0 to 7). In narrow mode, or with `kind`=3, the request resolves not taken and writes neither LR nor CTR.
- R5: A relative branch (`kind`=0) with `bo[2]`=1 sets `ctr_we` and `ctr_new`=`ctr`-1. It is taken only if that new value is nonzero and the condition test passes. For any other kind, `bo[2]` is ignored and `ctr_we` stays 0.
- R6: The relative target is `pc` + 2 × the sign-extended offset. In narrow mode the offset is `offs[5:0]`. In wide mode it is `{ext[3:0], offs[5:0]}`.
- R7: The conditional-branch target is `pc` + 2 × sign-extended `{ext[3:0], offs[1:0]}`. `offs[5:2]` is ignored.
- R8: A taken link-register branch (`kind`=1) goes to `lr` with bit 0 cleared. The old `lr` is used even when that same instruction links.
- R9: A legal request with `lk`=1 sets `lr_we` and gives `lr_new`=`pc`+2, whether or not the branch is taken.
- R10: A request that is not taken gives `npc`=`pc`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch request is present |
| kind | input | 2 | 0 relative, 1 to link register, 2 conditional, 3 reserved |
| wide | input | 1 | 1 = wide 16-bit mode, 0 = narrow mode |
| offs | input | 6 | Base offset bits (low two serve the conditional form) |
| ext | input | 4 | Wide-mode high offset extension |
| bo | input | 3 | [0] test enable, [1] invert, [2] count mode |
| bi | input | 5 | Condition bit index |
| lk | input | 1 | Write return address to link register |
| pc | input | XLEN | Address of the branch |
| cr | input | 32 | Condition register |
| lr | input | XLEN | Current link register |
| ctr | input | XLEN | Current count register |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Branch taken |
| npc | output | XLEN | Next fetch address |
| lr_we | output | 1 | Write `lr_new` to the link register |
| lr_new | output | XLEN | Return address |
| ctr_we | output | 1 | Write `ctr_new` to the count register |
| ctr_new | output | XLEN | Decremented count |

## Verification
Random requests mix all four kind codes and both modes. The condition registers are random, and the counts cluster near one so that both the zero and the nonzero results after decrement occur. Directed cases set up pairs that differ in one field only. These show whether the index is truncated in narrow mode, whether the test enable is forced on in the conditional form, and whether the inverter has an effect. They also show whether the sign extension is taken from the right bit in each offset layout. Other cases show whether counting leaks into non-relative kinds, and whether a linking register branch reads the old link value.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    BK_REL  = 2'd0,
    BK_LR   = 2'd1,
    BK_COND = 2'd2,
    BK_RSVD = 2'd3
  } br_kind_e;
endpackage

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int CR_W = 32,
  parameter int BI_W = 5
) (
  input  br_kind_e          kind,
  input  logic              wide,
  input  logic [2:0]        bo,
  input  logic [BI_W-1:0]   bi,
  input  logic [CR_W-1:0]   cr,
  output logic              legal,
  output logic              pass
);
  localparam int TOP = CR_W - 1;
  logic [BI_W-1:0] idx;
  logic            en;
  logic            tbit;

  always_comb begin
    if (kind == BK_COND)  idx = BI_W'(bi[2:0]);
    else if (wide)        idx = bi;
    else                  idx = BI_W'(bi[1:0]);
    en    = (kind == BK_COND) ? 1'b1 : bo[0];
    tbit  = cr[TOP - int'(idx)];
    pass  = !en || (tbit ^ bo[1]);
    legal = (kind == BK_REL) || (kind == BK_LR) || (kind == BK_COND && wide);
  end
endmodule

// File: rtl/cbr_ctr.sv
module cbr_ctr
  import cbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  br_kind_e          kind,
  input  logic              cnt_mode,
  input  logic [XLEN-1:0]   ctr,
  output logic              dec_en,
  output logic [XLEN-1:0]   ctr_dec,
  output logic              ctr_ok
);
  always_comb begin
    dec_en  = (kind == BK_REL) && cnt_mode;
    ctr_dec = ctr - XLEN'(1);
    ctr_ok  = !dec_en || (ctr_dec != '0);
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFS_W = 6,
  parameter int EXT_W = 4,
  parameter int OO_W  = 2
) (
  input  br_kind_e           kind,
  input  logic               wide,
  input  logic [OFS_W-1:0]   offs,
  input  logic [EXT_W-1:0]   ext,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    lr,
  output logic [XLEN-1:0]    tgt,
  output logic [XLEN-1:0]    seq
);
  localparam int LONG_W = OFS_W + EXT_W;
  localparam int COND_W = OO_W + EXT_W;

  logic [LONG_W-1:0] f_long;
  logic [COND_W-1:0] f_cond;
  logic [XLEN-1:0]   sx_short, sx_long, sx_cond, hw_off;

  always_comb begin
    f_long   = {ext, offs};
    f_cond   = {ext, offs[OO_W-1:0]};
    sx_short = {{(XLEN-OFS_W){offs[OFS_W-1]}}, offs};
    sx_long  = {{(XLEN-LONG_W){f_long[LONG_W-1]}}, f_long};
    sx_cond  = {{(XLEN-COND_W){f_cond[COND_W-1]}}, f_cond};
    if (kind == BK_COND) hw_off = sx_cond;
    else if (wide)       hw_off = sx_long;
    else                 hw_off = sx_short;
    seq = pc + XLEN'(2);
    if (kind == BK_LR) tgt = lr & ~XLEN'(1);
    else               tgt = pc + (hw_off << 1);
  end
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CR_W  = 32,
  parameter int BI_W  = 5,
  parameter int OFS_W = 6,
  parameter int EXT_W = 4,
  parameter int OO_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        kind,
  input  logic              wide,
  input  logic [OFS_W-1:0]  offs,
  input  logic [EXT_W-1:0]  ext,
  input  logic [2:0]        bo,
  input  logic [BI_W-1:0]   bi,
  input  logic              lk,
  input  logic [XLEN-1:0]   pc,
  input  logic [CR_W-1:0]   cr,
  input  logic [XLEN-1:0]   lr,
  input  logic [XLEN-1:0]   ctr,
  output logic              out_valid,
  output logic              taken,
  output logic [XLEN-1:0]   npc,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_new,
  output logic              ctr_we,
  output logic [XLEN-1:0]   ctr_new
);
  br_kind_e        k;
  logic            legal, pass, dec_en, ctr_ok, go;
  logic [XLEN-1:0] ctr_dec, tgt, seq;

  assign k = br_kind_e'(kind);

  cbr_cond #(.CR_W(CR_W), .BI_W(BI_W)) u_cond (
    .kind(k), .wide(wide), .bo(bo), .bi(bi), .cr(cr),
    .legal(legal), .pass(pass)
  );

  cbr_ctr #(.XLEN(XLEN)) u_ctr (
    .kind(k), .cnt_mode(bo[2]), .ctr(ctr),
    .dec_en(dec_en), .ctr_dec(ctr_dec), .ctr_ok(ctr_ok)
  );

  cbr_target #(.XLEN(XLEN), .OFS_W(OFS_W), .EXT_W(EXT_W), .OO_W(OO_W)) u_tgt (
    .kind(k), .wide(wide), .offs(offs), .ext(ext), .pc(pc), .lr(lr),
    .tgt(tgt), .seq(seq)
  );

  assign go = legal && pass && ctr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      npc       <= '0;
      lr_we     <= 1'b0;
      lr_new    <= '0;
      ctr_we    <= 1'b0;
      ctr_new   <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && go;
      npc       <= go ? tgt : seq;
      lr_we     <= in_valid && legal && lk;
      lr_new    <= seq;
      ctr_we    <= in_valid && dec_en;
      ctr_new   <= ctr_dec;
    end
  end

  // R1: result follows a request by one cycle, and only a request
  a_r1_valid_pipe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !taken && !lr_we && !ctr_we));
  // R5: counting never touches non-relative kinds
  a_r5_ctr_only_rel: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind != 2'd0) |=> !ctr_we);
  // R5: a counted branch taken implies a nonzero new count
  a_r5_taken_nonzero: assert property (@(posedge clk) disable iff (rst)
    (taken && ctr_we) |-> (ctr_new != '0));
  // R10: not taken falls through to the next halfword
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (taken || npc == $past(pc) + XLEN'(2)));
  // R8: link-register target is halfword aligned
  a_r8_lr_align: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd1) |=> (!taken || npc[0] == 1'b0));
  // R9: relative linking writes the return address
  a_r9_link_rel: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lk && kind == 2'd0) |=> (lr_we && lr_new == $past(pc) + XLEN'(2)));
  // R4: conditional form in narrow mode never writes state
  a_r4_narrow_cond: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == 2'd2 && !wide) |=> (!taken && !lr_we && !ctr_we));
endmodule

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  kind = '0;
  logic        wide = 1'b0;
  logic [5:0]  offs = '0;
  logic [3:0]  ext = '0;
  logic [2:0]  bo = '0;
  logic [4:0]  bi = '0;
  logic        lk = 1'b0;
  logic [63:0] pc = '0;
  logic [31:0] cr = '0;
  logic [63:0] lr = '0;
  logic [63:0] ctr = '0;
  logic        out_valid, taken, lr_we, ctr_we;
  logic [63:0] npc, lr_new, ctr_new;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cbr_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .wide(wide),
    .offs(offs), .ext(ext), .bo(bo), .bi(bi), .lk(lk), .pc(pc), .cr(cr),
    .lr(lr), .ctr(ctr), .out_valid(out_valid), .taken(taken), .npc(npc),
    .lr_we(lr_we), .lr_new(lr_new), .ctr_we(ctr_we), .ctr_new(ctr_new)
  );

  function automatic void model(output bit tk, output logic [63:0] np,
                                output bit lwe, output logic [63:0] lnew,
                                output bit cwe, output logic [63:0] cnew);
    int idx; bit en, ok, legal; longint off; logic [63:0] seq, tg;
    legal = (kind == 2'd0) || (kind == 2'd1) || (kind == 2'd2 && wide);
    if (kind == 2'd2) begin idx = int'(bi[2:0]); en = 1; end
    else begin idx = wide ? int'(bi) : int'(bi[1:0]); en = bo[0]; end
    ok = !en || (cr[31-idx] ^ bo[1]);
    cwe = legal && kind == 2'd0 && bo[2];
    cnew = ctr - 64'd1;
    if (cwe && cnew == 64'd0) ok = 0;
    if (kind == 2'd2) off = longint'($signed({ext, offs[1:0]}));
    else if (wide)    off = longint'($signed({ext, offs}));
    else              off = longint'($signed(offs));
    seq = pc + 64'd2;
    tg = (kind == 2'd1) ? (lr & ~64'd1) : (pc + 64'(off * 2));
    tk = legal && ok;
    np = tk ? tg : seq;
    lwe = legal && lk;
    lnew = seq;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic go(input string tag);
    bit tk, lwe, cwe; logic [63:0] np, lnew, cnew;
    model(tk, np, lwe, lnew, cwe, cnew);
    @(negedge clk);
    in_valid = 1'b1;
    model(tk, np, lwe, lnew, cwe, cnew);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(tag, "valid", {63'd0, out_valid}, 64'd1);
    check(tag, "taken", {63'd0, taken}, {63'd0, tk});
    check(tag, "npc", npc, np);
    check(tag, "lr_we", {63'd0, lr_we}, {63'd0, lwe});
    if (lwe) check(tag, "lr_new", lr_new, lnew);
    check(tag, "ctr_we", {63'd0, ctr_we}, {63'd0, cwe});
    if (cwe) check(tag, "ctr_new", ctr_new, cnew);
  endtask

  task automatic setf(input logic [1:0] k, input bit w, input logic [5:0] o,
                      input logic [3:0] e, input logic [2:0] b, input logic [4:0] i,
                      input bit l);
    kind = k; wide = w; offs = o; ext = e; bo = b; bi = i; lk = l;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "rst valid", {63'd0, out_valid}, 64'd0);
    check("R1", "rst taken", {63'd0, taken}, 64'd0);
    check("R1", "rst lr_we", {63'd0, lr_we}, 64'd0);
    check("R1", "rst ctr_we", {63'd0, ctr_we}, 64'd0);
    @(negedge clk); rst = 1'b0;

    pc = 64'h1000; lr = 64'h2345; ctr = 64'd7;
    // R2 narrow test: bit 2 of CR0
    cr = 32'h2000_0000; setf(2'd0, 0, 6'd4, 4'd0, 3'b001, 5'd2, 0); go("R2");
    cr = 32'h0000_0000; go("R2");
    setf(2'd0, 0, 6'd4, 4'd0, 3'b011, 5'd2, 0); go("R2");
    setf(2'd0, 0, 6'd4, 4'd0, 3'b000, 5'd2, 0); go("R2");
    // R2 upper index bits ignored in narrow mode: bi=5 tests bit 1
    cr = 32'h4000_0000; setf(2'd0, 0, 6'd4, 4'd0, 3'b001, 5'd5, 0); go("R2");
    // R3 wide reach to bit 20
    cr = 32'h0000_0800; setf(2'd1, 1, 6'd0, 4'd0, 3'b001, 5'd20, 0); go("R3");
    cr = 32'h0000_0000; go("R3");
    // R4 conditional: test forced on, CR1 bit, narrow illegal
    setf(2'd2, 1, 6'd3, 4'd0, 3'b000, 5'd6, 0); go("R4");
    cr = 32'h0200_0000; go("R4");
    setf(2'd2, 1, 6'd3, 4'd0, 3'b010, 5'd6, 0); go("R4");
    setf(2'd2, 0, 6'd3, 4'd0, 3'b000, 5'd6, 1); go("R4");
    setf(2'd3, 1, 6'd3, 4'd0, 3'b100, 5'd6, 1); go("R4");
    // R5 count mode
    ctr = 64'd1; setf(2'd0, 0, 6'd8, 4'd0, 3'b100, 5'd0, 0); go("R5");
    ctr = 64'd5; go("R5");
    ctr = 64'd0; go("R5");
    ctr = 64'd5; setf(2'd1, 1, 6'd8, 4'd0, 3'b100, 5'd0, 0); go("R5");
    setf(2'd2, 1, 6'd8, 4'd0, 3'b100, 5'd0, 0); go("R5");
    // R6 offsets and sign
    setf(2'd0, 0, 6'h3f, 4'h0, 3'b000, 5'd0, 0); go("R6");
    setf(2'd0, 1, 6'h00, 4'h8, 3'b000, 5'd0, 0); go("R6");
    setf(2'd0, 1, 6'h3f, 4'h7, 3'b000, 5'd0, 0); go("R6");
    // R7 conditional offset, offs[5:2] ignored
    cr = 32'h8000_0000;
    setf(2'd2, 1, 6'b111110, 4'hF, 3'b000, 5'd0, 0); go("R7");
    setf(2'd2, 1, 6'b000001, 4'h7, 3'b000, 5'd0, 0); go("R7");
    // R8 / R11-like: LR target, old LR used when linking
    lr = 64'hABCD_0007; setf(2'd1, 0, 6'd0, 4'd0, 3'b000, 5'd0, 1); go("R8");
    // R9 link when not taken
    cr = 32'h0; setf(2'd0, 0, 6'd4, 4'd0, 3'b001, 5'd0, 1); go("R9");
    // R10 fallthrough
    setf(2'd1, 1, 6'd4, 4'd0, 3'b011, 5'd0, 0); cr = 32'hFFFF_FFFF; go("R10");
    // R1 idle cycle
    @(negedge clk); @(posedge clk); #1;
    check("R1", "idle valid", {63'd0, out_valid}, 64'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      setf(2'($urandom), 1'($urandom), 6'($urandom), 4'($urandom),
           3'($urandom), 5'($urandom), 1'($urandom));
      pc = {$urandom, $urandom} & ~64'd1;
      lr = {$urandom, $urandom};
      cr = $urandom;
      r = int'($urandom % 4);
      ctr = (r == 0) ? 64'd1 : (r == 1) ? 64'd2 : {32'd0, $urandom};
      go("R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule